// File: doc/BRIEF.md
# Rectangle fill engine

The engine paints a solid rectangle into a 1280 by 1024 framebuffer from one already decoded fill packet. The packet carries four words: a line width, an attribute and two corner words. Each corner word is bit-packed and offset by the line width. The engine removes that offset and extracts the column and row of each corner. It turns the attribute into one pixel value and then walks the rectangle row by row, one pixel per clock, through a plain write port (enable, column, row, data). The fill reaches past the second corner's row by a count derived from the line width.

While it fills, the engine keeps a dirty bounding box of columns and rows for the display refresh logic. A static mode input picks between 24-bit pixels, which carry a three-channel gray level, and 8-bit pixels, which carry the attribute's low byte.

Top module: `rect_fill_engine`

## Requirements
- R1: After reset, `busy`, `done`, `wr_en`, `box_cols_valid` and `box_rows_valid` are all low.
- R2: `start` is taken only while `busy` is low. A `start` while busy has no effect on the writes, on `done` or on the dirty box. No write is issued while idle.
- R3: The line-width word is subtracted (modulo 2^32) from each corner word before decoding. The column is bits 29:19 (11 bits) of the difference and the row is bits 12:3 (10 bits).
- R4: Rows run from the first corner's row up to, but not including, the second corner's row plus (line width + 1) >> 2, where the increment wraps at 32 bits. Rows at or above 1024 are skipped. An empty row range writes nothing.
- R5: Columns run from the first corner's column up to, but not including, the second corner's column. The end column becomes 1280 when the end minus the start is strictly greater than 1280. An end not greater than the start writes nothing.
- R6: Writes appear one per clock in row-major order, with columns ascending within a row. The first write is visible right after the first clock edge that follows acceptance.
- R7: With `deep_mode` = 1, every write carries a gray level G in all three bytes of `wr_data`. G is set by attribute bits 23:16: 0 gives 0x00, 7 gives 0xC0, and any other value gives 0xFF.
- R8: With `deep_mode` = 0, `wr_data` is the attribute's bits 7:0 in bits 7:0, and bits 23:8 are zero.
- R9: `done` is a one-cycle pulse that is visible one cycle after the last write, at which point `busy` is low. A packet with N writes therefore raises `done` N+1 cycles after it is accepted, or 1 cycle after for N = 0.
- R10: On every accepted packet, even an empty one, `box_col_lo` takes the minimum of itself and the start column, and `box_col_hi` takes the maximum of itself and the (clamped) end column. `box_cols_valid` is then set.
- R11: `box_row_lo` and `box_row_hi` hold the lowest and highest row written since reset. `box_rows_valid` is set by the first write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| deep_mode | input | 1 | Static pixel depth: 1 = 24-bit gray, 0 = 8-bit |
| start | input | 1 | Packet present; taken when idle |
| lw_word | input | 32 | Line-width word |
| attr_word | input | 32 | Attribute word |
| corner_a | input | 32 | First corner word (packed, offset by line width) |
| corner_b | input | 32 | Second corner word (packed, offset by line width) |
| busy | output | 1 | A packet is being processed |
| done | output | 1 | One-cycle completion pulse |
| wr_en | output | 1 | Framebuffer write strobe |
| wr_x | output | 11 | Write column |
| wr_y | output | 10 | Write row |
| wr_data | output | 24 | Write pixel value |
| box_cols_valid | output | 1 | Column range of the dirty box is valid |
| box_col_lo | output | 11 | Lowest dirty column |
| box_col_hi | output | 11 | Highest dirty column bound |
| box_rows_valid | output | 1 | Row range of the dirty box is valid |
| box_row_lo | output | 10 | Lowest dirty row |
| box_row_hi | output | 10 | Highest dirty row |

## Verification
A packet accepted at clock edge E0 produces its k-th write right after edge Ek. `done` follows right after edge E(N+1), and the dirty box has settled by then. The bench samples every output on the falling edge. It counts falling edges from acceptance to `done` and compares that count with N+1. A monitor pops one expected write per cycle in which `wr_en` is high, so a gap or an extra write shows up both in the order check and in the cycle count. Box values are compared once, at the `done` edge.

// File: rtl/rfe_pkg.sv
package rfe_pkg;
  localparam int unsigned FB_WIDTH   = 1280;
  localparam int unsigned FB_HEIGHT  = 1024;
  localparam int unsigned WORD_BITS  = 32;
  localparam int unsigned COL_BITS   = 11;
  localparam int unsigned ROW_BITS   = 10;
  localparam int unsigned COL_SHIFT  = 19;
  localparam int unsigned ROW_SHIFT  = 3;
  localparam int unsigned PIXEL_BITS = 24;

  typedef enum logic [1:0] {
    SW_IDLE   = 2'd0,
    SW_RUN    = 2'd1,
    SW_FINISH = 2'd2
  } sweep_state_e;
endpackage

// File: rtl/rfe_unpack.sv
module rfe_unpack #(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned XW     = 11,
  parameter int unsigned YW     = 10,
  parameter int unsigned X_LSB  = 19,
  parameter int unsigned Y_LSB  = 3,
  parameter int unsigned FB_W   = 1280,
  parameter int unsigned FB_H   = 1024
) (
  input  logic [WORD_W-1:0] lw_word,
  input  logic [WORD_W-1:0] corner_a,
  input  logic [WORD_W-1:0] corner_b,
  output logic [XW-1:0]     x_lo,
  output logic [XW-1:0]     x_hi,
  output logic [YW-1:0]     y_lo,
  output logic [YW:0]       y_end,
  output logic              empty
);
  localparam int unsigned DIFF_W = XW + 1;
  localparam logic signed [DIFF_W-1:0] SPAN_LIMIT = DIFF_W'(FB_W);

  logic [WORD_W-1:0] va, vb, lw_inc, lw_rows;
  logic [XW-1:0]     xa, xb;
  logic [YW-1:0]     yb;
  logic [DIFF_W-1:0] span;
  logic [WORD_W:0]   row_sum;
  logic              clamp;
  logic              unused_bits;

  always_comb begin
    // remove the line-width offset before unpacking
    va      = corner_a - lw_word;
    vb      = corner_b - lw_word;
    xa      = va[X_LSB +: XW];
    xb      = vb[X_LSB +: XW];
    y_lo    = va[Y_LSB +: YW];
    yb      = vb[Y_LSB +: YW];
    lw_inc  = lw_word + WORD_W'(1);
    lw_rows = lw_inc >> 2;
    // column clamp: only when the span is strictly wider than the screen
    span    = {1'b0, xb} - {1'b0, xa};
    clamp   = $signed(span) > SPAN_LIMIT;
    x_lo    = xa;
    x_hi    = clamp ? XW'(FB_W) : xb;
    // exclusive row end, rows past the bottom edge are dropped
    row_sum = {1'b0, lw_rows} + (WORD_W+1)'(yb);
    y_end   = (row_sum >= (WORD_W+1)'(FB_H)) ? (YW+1)'(FB_H) : row_sum[YW:0];
    empty   = (x_hi <= xa) || ({1'b0, y_lo} >= y_end);
  end

  assign unused_bits = ^{va[WORD_W-1:X_LSB+XW], va[X_LSB-1:Y_LSB+YW], va[Y_LSB-1:0],
                         vb[WORD_W-1:X_LSB+XW], vb[X_LSB-1:Y_LSB+YW], vb[Y_LSB-1:0]};
endmodule

// File: rtl/rfe_shade.sv
module rfe_shade #(
  parameter int unsigned ATTR_W    = 32,
  parameter int unsigned PIX_W     = 24,
  parameter int unsigned CH_W      = 8,
  parameter int unsigned SEL_LSB   = 16,
  parameter int unsigned MID_CODE  = 7,
  parameter int unsigned MID_LEVEL = 192
) (
  input  logic [ATTR_W-1:0] attr,
  input  logic              deep,
  output logic [PIX_W-1:0]  pix
);
  localparam int unsigned CH_N = PIX_W / CH_W;

  logic [CH_W-1:0] sel;
  logic [CH_W-1:0] level;
  logic            unused_attr;

  always_comb begin
    sel = attr[SEL_LSB +: CH_W];
    if (sel == '0)                 level = '0;
    else if (sel == CH_W'(MID_CODE)) level = CH_W'(MID_LEVEL);
    else                           level = '1;
  end

  for (genvar c = 0; c < CH_N; c++) begin : g_chan
    if (c == 0) begin : g_low
      assign pix[c*CH_W +: CH_W] = deep ? level : attr[CH_W-1:0];
    end else begin : g_up
      assign pix[c*CH_W +: CH_W] = deep ? level : '0;
    end
  end

  assign unused_attr = ^{attr[ATTR_W-1:SEL_LSB+CH_W], attr[SEL_LSB-1:CH_W]};
endmodule

// File: rtl/rfe_sweep.sv
module rfe_sweep
  import rfe_pkg::*;
#(
  parameter int unsigned XW    = 11,
  parameter int unsigned YW    = 10,
  parameter int unsigned PIX_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [XW-1:0]    x_lo,
  input  logic [XW-1:0]    x_hi,
  input  logic [YW-1:0]    y_lo,
  input  logic [YW:0]      y_end,
  input  logic             empty,
  input  logic [PIX_W-1:0] pix,
  output logic             accept,
  output logic             row_hit,
  output logic [YW-1:0]    row_y,
  output logic             busy,
  output logic             done,
  output logic             wr_en,
  output logic [XW-1:0]    wr_x,
  output logic [YW-1:0]    wr_y,
  output logic [PIX_W-1:0] wr_data
);
  sweep_state_e     st;
  logic [XW-1:0]    xl_q, xh_q, cx;
  logic [YW-1:0]    cy;
  logic [YW:0]      ye_q;
  logic [PIX_W-1:0] pix_q;
  logic             col_last, row_last;

  assign busy     = (st != SW_IDLE);
  assign accept   = start && (st == SW_IDLE);
  assign row_hit  = (st == SW_RUN);
  assign row_y    = cy;
  assign col_last = ({1'b0, cx} + (XW+1)'(1)) == {1'b0, xh_q};
  assign row_last = ({1'b0, cy} + (YW+1)'(1)) == ye_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= SW_IDLE;
      xl_q    <= '0;
      xh_q    <= '0;
      ye_q    <= '0;
      pix_q   <= '0;
      cx      <= '0;
      cy      <= '0;
      done    <= 1'b0;
      wr_en   <= 1'b0;
      wr_x    <= '0;
      wr_y    <= '0;
      wr_data <= '0;
    end else begin
      wr_en <= 1'b0;
      done  <= 1'b0;
      unique case (st)
        SW_IDLE: begin
          if (start) begin
            xl_q  <= x_lo;
            xh_q  <= x_hi;
            ye_q  <= y_end;
            pix_q <= pix;
            cx    <= x_lo;
            cy    <= y_lo;
            st    <= empty ? SW_FINISH : SW_RUN;
          end
        end
        SW_RUN: begin
          wr_en   <= 1'b1;
          wr_x    <= cx;
          wr_y    <= cy;
          wr_data <= pix_q;
          if (col_last) begin
            cx <= xl_q;
            if (row_last) st <= SW_FINISH;
            else          cy <= cy + YW'(1);
          end else begin
            cx <= cx + XW'(1);
          end
        end
        SW_FINISH: begin
          done <= 1'b1;
          st   <= SW_IDLE;
        end
        default: st <= SW_IDLE;
      endcase
    end
  end

  AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (rst) !busy |-> !wr_en); // R2
  AST_WR_ROW_RANGE: assert property (@(posedge clk) disable iff (rst) wr_en |-> ({1'b0, wr_y} < ye_q)); // R4
  AST_WR_COL_RANGE: assert property (@(posedge clk) disable iff (rst) wr_en |-> (wr_x >= xl_q && wr_x < xh_q)); // R5
  AST_PIXEL_STEP: assert property (@(posedge clk) disable iff (rst)
    (wr_en && $past(wr_en) && wr_y == $past(wr_y)) |-> (wr_x == $past(wr_x) + XW'(1))); // R6
  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (rst) (wr_en && $past(wr_en)) |-> $stable(wr_data)); // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst) done |=> !done); // R9
  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (rst) done |-> (!wr_en && !busy)); // R9
endmodule

// File: rtl/rfe_dirty_box.sv
module rfe_dirty_box #(
  parameter int unsigned XW = 11,
  parameter int unsigned YW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          accept,
  input  logic [XW-1:0] x_lo,
  input  logic [XW-1:0] x_hi,
  input  logic          row_hit,
  input  logic [YW-1:0] row_y,
  output logic          cols_valid,
  output logic [XW-1:0] col_lo,
  output logic [XW-1:0] col_hi,
  output logic          rows_valid,
  output logic [YW-1:0] row_lo,
  output logic [YW-1:0] row_hi
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cols_valid <= 1'b0;
      col_lo     <= '0;
      col_hi     <= '0;
      rows_valid <= 1'b0;
      row_lo     <= '0;
      row_hi     <= '0;
    end else begin
      if (accept) begin
        cols_valid <= 1'b1;
        col_lo     <= (!cols_valid || x_lo < col_lo) ? x_lo : col_lo;
        col_hi     <= (!cols_valid || x_hi > col_hi) ? x_hi : col_hi;
      end
      if (row_hit) begin
        rows_valid <= 1'b1;
        row_lo     <= (!rows_valid || row_y < row_lo) ? row_y : row_lo;
        row_hi     <= (!rows_valid || row_y > row_hi) ? row_y : row_hi;
      end
    end
  end

  AST_ROWS_ORDERED: assert property (@(posedge clk) disable iff (rst) rows_valid |-> (row_lo <= row_hi)); // R11
  AST_ROWS_NEED_COLS: assert property (@(posedge clk) disable iff (rst) rows_valid |-> cols_valid); // R10
endmodule

// File: rtl/rect_fill_engine.sv
module rect_fill_engine
  import rfe_pkg::*;
#(
  parameter int unsigned WORD_W = WORD_BITS,
  parameter int unsigned XW     = COL_BITS,
  parameter int unsigned YW     = ROW_BITS,
  parameter int unsigned X_LSB  = COL_SHIFT,
  parameter int unsigned Y_LSB  = ROW_SHIFT,
  parameter int unsigned FB_W   = FB_WIDTH,
  parameter int unsigned FB_H   = FB_HEIGHT,
  parameter int unsigned PIX_W  = PIXEL_BITS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              deep_mode,
  input  logic              start,
  input  logic [WORD_W-1:0] lw_word,
  input  logic [WORD_W-1:0] attr_word,
  input  logic [WORD_W-1:0] corner_a,
  input  logic [WORD_W-1:0] corner_b,
  output logic              busy,
  output logic              done,
  output logic              wr_en,
  output logic [XW-1:0]     wr_x,
  output logic [YW-1:0]     wr_y,
  output logic [PIX_W-1:0]  wr_data,
  output logic              box_cols_valid,
  output logic [XW-1:0]     box_col_lo,
  output logic [XW-1:0]     box_col_hi,
  output logic              box_rows_valid,
  output logic [YW-1:0]     box_row_lo,
  output logic [YW-1:0]     box_row_hi
);
  logic [XW-1:0]    x_lo, x_hi;
  logic [YW-1:0]    y_lo, row_y;
  logic [YW:0]      y_end;
  logic             empty, accept, row_hit;
  logic [PIX_W-1:0] pix;

  rfe_unpack #(
    .WORD_W(WORD_W), .XW(XW), .YW(YW), .X_LSB(X_LSB), .Y_LSB(Y_LSB),
    .FB_W(FB_W), .FB_H(FB_H)
  ) u_unpack (
    .lw_word(lw_word), .corner_a(corner_a), .corner_b(corner_b),
    .x_lo(x_lo), .x_hi(x_hi), .y_lo(y_lo), .y_end(y_end), .empty(empty)
  );

  rfe_shade #(.ATTR_W(WORD_W), .PIX_W(PIX_W)) u_shade (
    .attr(attr_word), .deep(deep_mode), .pix(pix)
  );

  rfe_sweep #(.XW(XW), .YW(YW), .PIX_W(PIX_W)) u_sweep (
    .clk(clk), .rst(rst), .start(start),
    .x_lo(x_lo), .x_hi(x_hi), .y_lo(y_lo), .y_end(y_end), .empty(empty), .pix(pix),
    .accept(accept), .row_hit(row_hit), .row_y(row_y),
    .busy(busy), .done(done), .wr_en(wr_en), .wr_x(wr_x), .wr_y(wr_y), .wr_data(wr_data)
  );

  rfe_dirty_box #(.XW(XW), .YW(YW)) u_box (
    .clk(clk), .rst(rst), .accept(accept), .x_lo(x_lo), .x_hi(x_hi),
    .row_hit(row_hit), .row_y(row_y),
    .cols_valid(box_cols_valid), .col_lo(box_col_lo), .col_hi(box_col_hi),
    .rows_valid(box_rows_valid), .row_lo(box_row_lo), .row_hi(box_row_hi)
  );

  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst) accept |=> busy); // R2
  AST_NO_DONE_AT_ACCEPT: assert property (@(posedge clk) disable iff (rst) accept |=> !done); // R9
endmodule

// File: tb/rect_fill_engine_test.sv
module rect_fill_engine_test;
  typedef struct {
    int          x;
    int          y;
    logic [23:0] d;
    string       req;
  } pix_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        deep_mode = 1'b1;
  logic        start = 1'b0;
  logic [31:0] lw_word = '0, attr_word = '0, corner_a = '0, corner_b = '0;
  logic        busy, done, wr_en;
  logic [10:0] wr_x;
  logic [9:0]  wr_y;
  logic [23:0] wr_data;
  logic        box_cols_valid, box_rows_valid;
  logic [10:0] box_col_lo, box_col_hi;
  logic [9:0]  box_row_lo, box_row_hi;

  int   checks = 0;
  int   errors = 0;
  int   cycles = 0;
  pix_t expq[$];

  bit mb_cv = 0, mb_rv = 0;
  int mb_xlo = 0, mb_xhi = 0, mb_ylo = 0, mb_yhi = 0;

  always #2 clk = ~clk;

  rect_fill_engine uut (
    .clk(clk), .rst(rst), .deep_mode(deep_mode), .start(start),
    .lw_word(lw_word), .attr_word(attr_word), .corner_a(corner_a), .corner_b(corner_b),
    .busy(busy), .done(done), .wr_en(wr_en), .wr_x(wr_x), .wr_y(wr_y), .wr_data(wr_data),
    .box_cols_valid(box_cols_valid), .box_col_lo(box_col_lo), .box_col_hi(box_col_hi),
    .box_rows_valid(box_rows_valid), .box_row_lo(box_row_lo), .box_row_hi(box_row_hi)
  );

  function automatic logic [31:0] pk(input int x, input int y, input logic [31:0] lw);
    return ((32'(x) << 19) | (32'(y) << 3)) + lw;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // monitor: one expected write popped per observed write
  always @(negedge clk) begin
    if (!rst && wr_en) begin
      checks++;
      if (expq.size() == 0) begin
        errors++;
        $display("FAIL R2 unexpected write: actual x=%0d y=%0d expected none", wr_x, wr_y);
      end else begin
        pix_t e;
        e = expq.pop_front();
        if (int'(wr_x) != e.x || int'(wr_y) != e.y || wr_data != e.d) begin
          errors++;
          $display("FAIL %s R6 write: actual (%0d,%0d,%h) expected (%0d,%0d,%h)",
                   e.req, wr_x, wr_y, wr_data, e.x, e.y, e.d);
        end
      end
    end
  end

  task automatic check_box(input string req);
    check(box_cols_valid == mb_cv, "R10", {req, " cols_valid"}, box_cols_valid, mb_cv);
    check(int'(box_col_lo) == mb_xlo, "R10", {req, " col_lo"}, box_col_lo, mb_xlo);
    check(int'(box_col_hi) == mb_xhi, "R10", {req, " col_hi"}, box_col_hi, mb_xhi);
    check(box_rows_valid == mb_rv, "R11", {req, " rows_valid"}, box_rows_valid, mb_rv);
    if (mb_rv) begin
      check(int'(box_row_lo) == mb_ylo, "R11", {req, " row_lo"}, box_row_lo, mb_ylo);
      check(int'(box_row_hi) == mb_yhi, "R11", {req, " row_hi"}, box_row_hi, mb_yhi);
    end
  endtask

  task automatic run_packet(input bit deep, input logic [31:0] lw, input logic [31:0] attr,
                            input logic [31:0] ca, input logic [31:0] cb,
                            input string req, input bit poke);
    logic [31:0] va, vb, lwr;
    int x1, x2, y1, y2, yend, npix, cnt;
    logic [7:0]  g;
    logic [23:0] d;
    longint      ysum;
    va = ca - lw;  vb = cb - lw;
    x1 = int'(va[29:19]); y1 = int'(va[12:3]);
    x2 = int'(vb[29:19]); y2 = int'(vb[12:3]);
    lwr = (lw + 32'd1) >> 2;
    if (x2 - x1 > 1280) x2 = 1280;                          // R5
    ysum = longint'(y2) + longint'(lwr);
    yend = (ysum >= 1024) ? 1024 : int'(ysum);               // R4
    g = (attr[23:16] == 8'd0) ? 8'h00 : (attr[23:16] == 8'd7) ? 8'hC0 : 8'hFF;
    d = deep ? {g, g, g} : {16'h0, attr[7:0]};               // R7 R8
    npix = 0;
    if (x2 > x1) begin
      for (int y = y1; y < yend; y++) begin
        for (int x = x1; x < x2; x++) begin
          pix_t p;
          p.x = x; p.y = y; p.d = d; p.req = req;
          expq.push_back(p);
          npix++;
          if (!mb_rv || y < mb_ylo) mb_ylo = y;
          if (!mb_rv || y > mb_yhi) mb_yhi = y;
          mb_rv = 1;
        end
      end
    end
    if (!mb_cv || x1 < mb_xlo) mb_xlo = x1;
    if (!mb_cv || x2 > mb_xhi) mb_xhi = x2;
    mb_cv = 1;

    @(negedge clk);
    deep_mode = deep; lw_word = lw; attr_word = attr; corner_a = ca; corner_b = cb;
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      // start while busy with a different packet: must be ignored (R2)
      start = 1'b1; lw_word = 32'd0; attr_word = 32'h00FF_0000;
      corner_a = pk(2, 1, 0); corner_b = pk(2000, 900, 0);
    end
    cnt = 0;
    while (cnt < 5000) begin
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      cnt++;
      if (done) break;
    end
    check(cnt == npix + 1, "R9", {req, " cycles to done"}, cnt, npix + 1);
    check(busy == 1'b0, "R9", {req, " busy at done"}, busy, 0);
    check(expq.size() == 0, "R6", {req, " writes left"}, expq.size(), 0);
    expq.delete();
    check_box(req);
    @(negedge clk);
    check(done == 1'b0, "R9", {req, " done pulse width"}, done, 0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles == 150000) begin
        errors++;
        $display("FAIL R9 watchdog: actual no completion expected done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check(busy == 0, "R1", "busy", busy, 0);
    check(done == 0, "R1", "done", done, 0);
    check(wr_en == 0, "R1", "wr_en", wr_en, 0);
    check(box_cols_valid == 0, "R1", "cols_valid", box_cols_valid, 0);
    check(box_rows_valid == 0, "R1", "rows_valid", box_rows_valid, 0);

    run_packet(1, 32'd0, 32'h0000_0000, pk(10, 5, 0),   pk(14, 7, 0),   "R7 gray0", 0);
    run_packet(1, 32'd3, 32'h0007_0000, pk(100, 20, 3), pk(103, 21, 3), "R4 lw3", 0);
    run_packet(1, 32'd0, 32'h0005_3344, pk(40, 30, 0),  pk(42, 32, 0),  "R7 gray_other", 0);
    run_packet(0, 32'd0, 32'h0007_00AB, pk(60, 8, 0),   pk(65, 9, 0),   "R8 shallow", 0);
    run_packet(1, 32'd8, 32'h0007_0000, pk(20, 5, 0),   pk(22, 5, 8),   "R3 offset", 0);
    run_packet(1, 32'd0, 32'h0001_0000, pk(0, 3, 0),    pk(1500, 4, 0), "R5 clamp R2 poke", 1);
    run_packet(1, 32'd0, 32'h0000_0000, pk(100, 40, 0), pk(1380, 41, 0), "R5 exact", 0);
    run_packet(1, 32'd0, 32'h0007_0000, pk(1600, 50, 0), pk(1590, 60, 0), "R5 empty R10", 0);
    run_packet(1, 32'd12, 32'h0007_0000, pk(300, 1020, 12), pk(302, 1022, 12), "R4 bottom", 0);
    run_packet(0, 32'd0, 32'h0000_0011, pk(5, 9, 0),    pk(8, 9, 0),    "R4 no_rows", 0);

    // idle: no writes without start (R2)
    repeat (4) @(negedge clk);
    check(wr_en == 0 && busy == 0, "R2", "idle quiet", wr_en, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule